// File: doc/BRIEF.md
# I2C Byte-Memory Target

This block is a two-wire bus target that fronts a byte-wide memory array held inside the block. It runs on a fast system clock. Both bus lines pass through flop synchronizers, and the block looks for edges on the synchronized copies. It drives the data line only through an open-drain pull-down enable. The depth is set by the parameter `MEM_AW`, and the array holds 2^MEM_AW bytes. `MEM_AW = 14` gives the full 16K x 8 configuration. The default is smaller so that elaboration stays light.

A master writes by sending the matching device byte with the direction bit at 0. It then sends a high and a low pointer byte, then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps forward. A read is a device byte with the direction bit at 1. It streams bytes from the current pointer for as long as the master acknowledges. A write that stops after the two pointer bytes, followed by a repeated START and a read, gives a random read. A master-code byte raises a high-speed status flag, which STOP clears. Up to eight targets can share one bus, each told apart by its three strap inputs.

There is no streaming data interface at the block's edge. The only data path is the bus itself, and the bus has no back-pressure beyond its own acknowledge bits. Clock stretching is not used.

Top module: `i2cm_target`

## Requirements
- R1: A START is SDA falling while SCL is high. A START at any point releases SDA and abandons the transfer in progress. A partly received data byte is not written, and the next byte is taken as a device byte.
- R2: A device byte matches only when bits 7:4 equal 1010 and bits 3:1 equal `strap_i`. On a mismatch the block gives no acknowledge, keeps SDA released and writes nothing until the next START.
- R3: The block acknowledges a matching device byte, both pointer bytes and every data byte of a write. It does so by pulling SDA low for the whole ninth SCL pulse.
- R4: The pointer is loaded from the low `MEM_AW` bits of the 16-bit value {first pointer byte, second pointer byte}. The higher bits are ignored.
- R5: Each data byte of a write is stored at the pointer, and the pointer then increments. It wraps from 2^MEM_AW-1 to 0.
- R6: A device byte with bit 0 = 1 starts a read at the current pointer. Bytes go out MSB first. After each master acknowledge the next byte follows, from the incremented and wrapping pointer.
- R7: A master no-acknowledge after a read byte ends the read. SDA stays released until a START or a STOP.
- R8: A STOP is SDA rising while SCL is high. It abandons the transfer without writing a partly received byte, and it clears `hs_mode`.
- R9: A byte of the form 00001xxx in the device-byte position is not acknowledged. It sets `hs_mode` to 1 and touches no memory.
- R10: After reset `sda_oe` is 0, `hs_mode` is 0 and the pointer is 0. The array contents are not cleared by reset.
- R11: `sda_oe` goes active only while SCL is low. Every change the block makes to the line on an SCL fall appears SYNC_STAGES+1 system cycles after that fall reaches `scl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Select strap compared with device-byte bits 3:1 |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| hs_mode | output | 1 | High-speed mode flag, set by a master code and cleared by STOP |

## Verification
The synchronizer stages plus one edge-detect register set every result. An acknowledge, a released line or a read bit appears SYNC_STAGES+1 = 3 system cycles after SCL falls at the pin. A START or STOP takes effect the same number of cycles after the SDA edge. `hs_mode` changes on the SCL fall that closes the master-code byte. The bench waits six cycles in each quarter of an SCL period and samples SDA in the middle of the high phase. Every sample therefore lands at least three cycles after the latest possible change. Memory effects are checked by reading back through the bus and comparing against a byte model kept in the bench.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX, ST_IGN} tgt_state_e;
  typedef enum logic [1:0] {K_DEV, K_PHI, K_PLO, K_DATA} rx_kind_e;
  localparam logic [3:0] DEV_TYPE   = 4'b1010;
  localparam logic [4:0] MCODE_HEAD = 5'b00001;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '1;
        else        stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cm_bus_cond.sv
module i2cm_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk)
    if (we) arr[waddr] <= wdata;

  assign rdata = arr[raddr];
endmodule

// File: rtl/i2cm_target.sv
module i2cm_target
  import i2cm_pkg::*;
#(
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe,
  output logic       hs_mode
);
  localparam logic [MEM_AW-1:0] PTR_ONE = MEM_AW'(1);

  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e st_q;
  rx_kind_e   kind_q;
  logic [3:0] bitcnt_q;
  logic       in_ack_q, go_tx_q, mack_q;
  logic [7:0] shift_q, tx_q, phi_q, mem_rdata;
  logic [MEM_AW-1:0] ptr_q;
  logic       dev_hit, mcode, mem_we;

  i2cm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

  i2cm_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  assign dev_hit = (shift_q[7:4] == DEV_TYPE) && (shift_q[3:1] == strap_i);
  assign mcode   = (shift_q[7:3] == MCODE_HEAD);
  assign mem_we  = (st_q == ST_RX) && scl_fall && !in_ack_q &&
                   (bitcnt_q == 4'd8) && (kind_q == K_DATA);

  i2cm_mem #(.AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ptr_q), .wdata(shift_q),
    .raddr(ptr_q), .rdata(mem_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      kind_q   <= K_DEV;
      bitcnt_q <= '0;
      in_ack_q <= 1'b0;
      go_tx_q  <= 1'b0;
      mack_q   <= 1'b0;
      shift_q  <= '0;
      tx_q     <= '0;
      phi_q    <= '0;
      ptr_q    <= '0;
      sda_oe   <= 1'b0;
      hs_mode  <= 1'b0;
    end else if (start_det) begin
      st_q     <= ST_RX;
      kind_q   <= K_DEV;
      bitcnt_q <= '0;
      in_ack_q <= 1'b0;
      go_tx_q  <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      st_q     <= ST_IDLE;
      bitcnt_q <= '0;
      in_ack_q <= 1'b0;
      sda_oe   <= 1'b0;
      hs_mode  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && !in_ack_q && bitcnt_q != 4'd8) begin
            shift_q  <= {shift_q[6:0], sda_s};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall && in_ack_q) begin
            in_ack_q <= 1'b0;
            bitcnt_q <= '0;
            if (go_tx_q) begin
              st_q   <= ST_TX;
              tx_q   <= mem_rdata;
              sda_oe <= ~mem_rdata[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            unique case (kind_q)
              K_DEV: begin
                if (dev_hit) begin
                  sda_oe   <= 1'b1;
                  in_ack_q <= 1'b1;
                  go_tx_q  <= shift_q[0];
                  kind_q   <= K_PHI;
                end else begin
                  if (mcode) hs_mode <= 1'b1;
                  st_q <= ST_IGN;
                end
              end
              K_PHI: begin
                phi_q    <= shift_q;
                kind_q   <= K_PLO;
                sda_oe   <= 1'b1;
                in_ack_q <= 1'b1;
              end
              K_PLO: begin
                ptr_q    <= MEM_AW'({phi_q, shift_q});
                kind_q   <= K_DATA;
                sda_oe   <= 1'b1;
                in_ack_q <= 1'b1;
              end
              K_DATA: begin
                ptr_q    <= ptr_q + PTR_ONE;
                sda_oe   <= 1'b1;
                in_ack_q <= 1'b1;
              end
              default: st_q <= ST_IGN;
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            if (in_ack_q)                mack_q   <= ~sda_s;
            else if (bitcnt_q != 4'd8)   bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (in_ack_q) begin
              in_ack_q <= 1'b0;
              if (mack_q) begin
                tx_q     <= mem_rdata;
                sda_oe   <= ~mem_rdata[7];
                bitcnt_q <= '0;
              end else begin
                st_q   <= ST_IGN;
                sda_oe <= 1'b0;
              end
            end else if (bitcnt_q == 4'd8) begin
              sda_oe   <= 1'b0;
              in_ack_q <= 1'b1;
              mack_q   <= 1'b0;
              ptr_q    <= ptr_q + PTR_ONE;
            end else begin
              sda_oe <= ~tx_q[3'd7 - bitcnt_q[2:0]];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_target_chk.sv
module i2cm_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic hs_mode,
  input logic start_det,
  input logic stop_det,
  input logic ign_i
);
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  p_stop_hs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode);
  p_silent_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ign_i |-> !sda_oe);
  p_mcode_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |=> !sda_oe);
endmodule

bind i2cm_target i2cm_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .hs_mode(hs_mode), .start_det(start_det), .stop_det(stop_det),
  .ign_i(st_q == i2cm_pkg::ST_IGN));

// File: tb/test_i2cm_target.sv
module test_i2cm_target;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_oe, hs_mode, sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  i2cm_target #(.MEM_AW(AW)) i_i2cm_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .sda_oe(sda_oe), .hs_mode(hs_mode));

  int checks = 0, fails = 0, r11_viol = 0;
  logic [7:0]    model [DEPTH];
  logic [AW-1:0] eptr;
  logic          oe_prev = 1'b0;

  function automatic logic [7:0] dev_byte(input logic rd);
    return {4'b1010, strap, rd};
  endfunction

  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) r11_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, r);
      d = {d[6:0], r};
    end
    clk_bit(~mack, r);
  endtask

  task automatic set_ptr(input logic [15:0] a);
    logic ack;
    wbyte(dev_byte(1'b0), ack); chk("R3 dev ack", ack, 1'b1);
    wbyte(a[15:8], ack);        chk("R3 phi ack", ack, 1'b1);
    wbyte(a[7:0], ack);         chk("R3 plo ack", ack, 1'b1);
    eptr = a[AW-1:0];
  endtask

  task automatic wr(input logic [15:0] a, input int n);
    logic ack;
    logic [7:0] d;
    bstart(); set_ptr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wbyte(d, ack); chk("R3/R5 data ack", ack, 1'b1);
      model[eptr] = d; eptr++;
    end
    bstop();
  endtask

  task automatic rd_body(input int n);
    logic ack;
    logic r;
    logic [7:0] d;
    wbyte(dev_byte(1'b1), ack); chk("R3 read dev ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk("R6 read data", d, model[eptr]);
      eptr++;
    end
    repeat (4) @(negedge clk);
    chk("R7 released after nack", sda_oe, 1'b0);
    clk_bit(1'b1, r);
    chk("R7 stays silent", r, 1'b1);
    bstop();
  endtask

  task automatic rd_at(input logic [15:0] a, input int n);
    bstart(); set_ptr(a); bstart(); rd_body(n);
  endtask

  task automatic rd_cur(input int n);
    bstart(); rd_body(n);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; repeat (3) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(negedge clk); wd++;
      if (wd > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<190000", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic ack;
    logic r;
    logic [15:0] a;
    int n;
    void'($urandom(32'd5150));
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 sda_oe reset", sda_oe, 1'b0);
    chk("R10 hs_mode reset", hs_mode, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: pointer returns to zero after reset
    wr(16'h0000, 1);
    do_reset();
    eptr = '0;
    rd_cur(1);

    // R4: upper pointer bits ignored
    wr(16'hFC05, 1);
    rd_at(16'h0005, 1);

    // R5 / R6: wrap at the top of the array
    wr(16'(DEPTH - 2), 4);
    rd_at(16'(DEPTH - 2), 4);

    // R2: wrong strap and wrong type are not answered and write nothing
    wr(16'h0007, 1);
    bstart();
    wbyte({4'b1010, strap ^ 3'b001, 1'b0}, ack); chk("R2 strap mismatch nack", ack, 1'b0);
    wbyte(8'h00, ack); chk("R2 silent", ack, 1'b0);
    wbyte(8'h07, ack); chk("R2 silent", ack, 1'b0);
    wbyte(8'h99, ack); chk("R2 silent", ack, 1'b0);
    bstop();
    bstart();
    wbyte({4'b1011, strap, 1'b0}, ack); chk("R2 type mismatch nack", ack, 1'b0);
    bstop();
    rd_at(16'h0007, 1);

    // R1: START mid data byte aborts
    wr(16'h0020, 1);
    bstart(); set_ptr(16'h0020);
    for (int i = 0; i < 5; i++) clk_bit(1'(i & 1), r);
    bstart();
    rd_body(1);

    // R8: STOP mid data byte aborts
    wr(16'h0030, 1);
    bstart(); set_ptr(16'h0030);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, r);
    bstop();
    rd_at(16'h0030, 1);

    // R9: master code
    bstart();
    wbyte(8'h0D, ack); chk("R9 master code nack", ack, 1'b0);
    chk("R9 hs_mode set", hs_mode, 1'b1);
    bstart();
    eptr = 10'h031;
    rd_body(1);
    chk("R8 hs_mode cleared by stop", hs_mode, 1'b0);

    // random bursts
    for (int k = 0; k < 16; k++) begin
      a = 16'($urandom);
      n = 1 + int'($urandom % 6);
      wr(a, n);
      rd_at({6'b0, a[AW-1:0]}, n);
    end

    chk("R11 drive only with SCL low", r11_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule